// File: doc/BRIEF.md
# Video Line and Pixel Trigger Sequencer

This block is the trigger front end of an on-chip logic analyzer that watches a 10-bit digital video word stream at the full design clock rate. It fires a single capture pulse at one exact pixel of one exact video line. The pulse starts capture into a trace buffer that lives outside the block.

To do this the block steps through a fixed chain of matches. First it looks for an end-of-active-video marker. It then reads the line number that follows the marker and compares it with a target. Next it looks for the start-of-active-video marker of that line, and finally it counts a programmed number of words.

Each marker is a three-word preamble, matched by three comparators whose values are set at run time, followed by a status word. Bit 6 of that status word tells the two markers apart. The target line, the word count and the preamble values are live inputs, so software can aim the trigger at a new pixel between arming cycles without rebuilding the logic. An arm pulse restarts the chain, and after firing the block waits until it is armed again.

Top module: `vid_trig_seq`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `stage_o` reads 0 (idle) and `trig_o` is 0. Stage codes: 0 idle, 1 hunting end-of-active marker, 2 reading line number, 3 hunting start-of-active marker, 4 counting words, 5 done.
- R2: A cycle with `arm` high sets `stage_o` to 1 on the next cycle from any stage. The word presented in that cycle is not processed, even when it would complete a stage or fire the trigger.
- R3: In stage 1, three consecutive valid words equal to `cfg_pre0`, `cfg_pre1` and `cfg_pre2`, followed by a valid status word with bit 6 set, move the block to stage 2. A status word with bit 6 clear leaves it in stage 1.
- R4: A preamble that breaks part way restarts matching. A breaking word that equals `cfg_pre0` counts as the first word of a new preamble.
- R5: In stage 2 the block takes the next two valid words and forms line = {second[5:2], first[8:2]}. If this equals `cfg_line` it moves to stage 3, otherwise it goes back to stage 1.
- R6: In stage 3, a preamble followed by a status word with bit 6 clear moves the block to stage 4. A status word with bit 6 set leaves it in stage 3.
- R7: With `cfg_count` = N, the (N+1)th valid word after the start marker's status word fires the trigger. `trig_o` is high for exactly one cycle, the cycle after that word, and in that same cycle `stage_o` becomes 5.
- R8: Stage 5 holds, with no further trigger pulse, whatever words arrive, until `arm` is raised.
- R9: A cycle with `word_vld` low and `arm` low leaves the stage, the preamble progress, the line reading and the word count unchanged.
- R10: The comparator values, target line and count are read live, so new values take effect for the next arming without any other action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Design clock |
| rst | input | 1 | Synchronous active-high reset |
| arm | input | 1 | Restart the sequence at stage 1 |
| word_i | input | 10 | Monitored video word |
| word_vld | input | 1 | Qualifies `word_i` |
| cfg_pre0 | input | 10 | First preamble comparator value |
| cfg_pre1 | input | 10 | Second preamble comparator value |
| cfg_pre2 | input | 10 | Third preamble comparator value |
| cfg_line | input | 11 | Target line number |
| cfg_count | input | 16 | Words to skip after the start marker |
| trig_o | output | 1 | One-cycle capture trigger |
| stage_o | output | 3 | Current stage code |

## Verification
The arm input and the word that completes a stage can arrive in the same cycle. The case that matters most is arm arriving together with the final counted word. The bench provokes this directly by raising arm alongside the word that would fire the trigger. The expected result is stage 1 with no trigger pulse, because arm takes priority. Randomly placed arm pulses also land on marker, line and count words during long random streams, and a cycle-by-cycle reference model computed from the requirements judges each of those cases.

// File: rtl/vt_pkg.sv
package vt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_EAV  = 3'd1,
    ST_LINE = 3'd2,
    ST_SAV  = 3'd3,
    ST_CNT  = 3'd4,
    ST_DONE = 3'd5
  } vt_stage_e;
endpackage

// File: rtl/vt_pre_det.sv
// Three-comparator preamble tracker; flags the status word after a full match.
module vt_pre_det #(
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          vld,
  input  logic [DW-1:0] word,
  input  logic [DW-1:0] p0,
  input  logic [DW-1:0] p1,
  input  logic [DW-1:0] p2,
  output logic          xyz_hit
);
  localparam int PW = 2;
  localparam logic [PW-1:0] POS_XYZ = PW'(3);

  logic [PW-1:0] pos;
  logic [DW-1:0] exp_w;
  logic          is_p0;

  always_comb begin
    case (pos)
      2'd0:    exp_w = p0;
      2'd1:    exp_w = p1;
      default: exp_w = p2;
    endcase
  end

  assign is_p0   = (word == p0);
  assign xyz_hit = en && vld && (pos == POS_XYZ);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      pos <= '0;
    end else if (vld) begin
      if (pos == POS_XYZ)     pos <= is_p0 ? PW'(1) : '0;
      else if (word == exp_w) pos <= pos + PW'(1);
      else                    pos <= is_p0 ? PW'(1) : '0;
    end
  end

  // R9: progress holds over invalid words
  a_r9_pos_hold: assert property (@(posedge clk) disable iff (rst)
    (en && !vld) |=> $stable(pos));
  // R4: a breaking first-preamble word restarts at position one
  a_r4_restart: assert property (@(posedge clk) disable iff (rst)
    (en && vld && pos != POS_XYZ && word != exp_w && is_p0) |=> (pos == PW'(1)));
endmodule

// File: rtl/vt_line_cmp.sv
// Reads the two line-number words and compares the assembled number.
module vt_line_cmp #(
  parameter int DW     = 10,
  parameter int LW     = 11,
  parameter int LO_W   = 7,
  parameter int FLD_LSB = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          vld,
  input  logic [DW-1:0] word,
  input  logic [LW-1:0] cfg_line,
  output logic          done,
  output logic          match
);
  localparam int HI_W = LW - LO_W;

  logic            half;
  logic [LO_W-1:0] lo_q;

  always_ff @(posedge clk) begin
    if (rst || !en) half <= 1'b0;
    else if (vld)   half <= ~half;
  end

  always_ff @(posedge clk) begin
    if (rst)                     lo_q <= '0;
    else if (en && vld && !half) lo_q <= word[FLD_LSB +: LO_W];
  end

  assign done  = en && vld && half;
  assign match = ({word[FLD_LSB +: HI_W], lo_q} == cfg_line);

  // R5: first valid word moves to the second half
  a_r5_half_step: assert property (@(posedge clk) disable iff (rst)
    (en && vld && !half) |=> half);
endmodule

// File: rtl/vt_word_cnt.sv
// Post-marker word counter; fires on the (limit+1)th valid word.
module vt_word_cnt #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          vld,
  input  logic [CW-1:0] limit,
  output logic          fire
);
  logic [CW-1:0] cnt;

  assign fire = en && vld && (cnt == limit);

  always_ff @(posedge clk) begin
    if (rst || !en) cnt <= '0;
    else if (vld)   cnt <= fire ? '0 : cnt + CW'(1);
  end

  // R7: each counted word advances the count by one
  a_r7_cnt_step: assert property (@(posedge clk) disable iff (rst)
    (en && vld && !fire) |=> (cnt == $past(cnt) + CW'(1)));
  // R9: count holds over invalid words
  a_r9_cnt_hold: assert property (@(posedge clk) disable iff (rst)
    (en && !vld) |=> $stable(cnt));
endmodule

// File: rtl/vid_trig_seq.sv
module vid_trig_seq
  import vt_pkg::*;
#(
  parameter int DW    = 10,
  parameter int LW    = 11,
  parameter int CW    = 16,
  parameter int H_BIT = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          arm,
  input  logic [DW-1:0] word_i,
  input  logic          word_vld,
  input  logic [DW-1:0] cfg_pre0,
  input  logic [DW-1:0] cfg_pre1,
  input  logic [DW-1:0] cfg_pre2,
  input  logic [LW-1:0] cfg_line,
  input  logic [CW-1:0] cfg_count,
  output logic          trig_o,
  output logic [2:0]    stage_o
);
  vt_stage_e st, st_nx;
  logic en_srch, en_line, en_cnt;
  logic xyz_hit, ln_done, ln_match, cnt_fire, h_flag;
  logic trig_q;

  assign en_srch = (st == ST_EAV || st == ST_SAV) && !arm;
  assign en_line = (st == ST_LINE) && !arm;
  assign en_cnt  = (st == ST_CNT) && !arm;
  assign h_flag  = word_i[H_BIT];

  vt_pre_det #(.DW(DW)) u_pre (
    .clk(clk), .rst(rst), .en(en_srch), .vld(word_vld), .word(word_i),
    .p0(cfg_pre0), .p1(cfg_pre1), .p2(cfg_pre2), .xyz_hit(xyz_hit)
  );

  vt_line_cmp #(.DW(DW), .LW(LW)) u_line (
    .clk(clk), .rst(rst), .en(en_line), .vld(word_vld), .word(word_i),
    .cfg_line(cfg_line), .done(ln_done), .match(ln_match)
  );

  vt_word_cnt #(.CW(CW)) u_cnt (
    .clk(clk), .rst(rst), .en(en_cnt), .vld(word_vld),
    .limit(cfg_count), .fire(cnt_fire)
  );

  always_comb begin
    st_nx = st;
    if (arm) begin
      st_nx = ST_EAV;
    end else begin
      case (st)
        ST_EAV:  if (xyz_hit && h_flag)  st_nx = ST_LINE;
        ST_LINE: if (ln_done)            st_nx = ln_match ? ST_SAV : ST_EAV;
        ST_SAV:  if (xyz_hit && !h_flag) st_nx = ST_CNT;
        ST_CNT:  if (cnt_fire)           st_nx = ST_DONE;
        default: st_nx = st;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      trig_q <= 1'b0;
    end else begin
      st     <= st_nx;
      trig_q <= cnt_fire;
    end
  end

  assign trig_o  = trig_q;
  assign stage_o = st;

  // R1: reset state
  a_r1_reset: assert property (@(posedge clk)
    rst |=> (stage_o == 3'd0 && !trig_o));
  // R2: arm restarts at the first stage
  a_r2_arm: assert property (@(posedge clk) disable iff (rst)
    arm |=> (stage_o == 3'd1 && !trig_o));
  // R7: trigger is a single-cycle pulse that coincides with done
  a_r7_pulse: assert property (@(posedge clk) disable iff (rst)
    trig_o |=> !trig_o);
  a_r7_with_done: assert property (@(posedge clk) disable iff (rst)
    trig_o |-> (stage_o == 3'd5));
  // R8: done holds until re-armed
  a_r8_done_hold: assert property (@(posedge clk) disable iff (rst)
    (stage_o == 3'd5 && !arm) |=> (stage_o == 3'd5 && !trig_o));
  // R9: invalid words change nothing
  a_r9_stage_hold: assert property (@(posedge clk) disable iff (rst)
    (!word_vld && !arm) |=> $stable(stage_o));
endmodule

// File: tb/vid_trig_seq_test.sv
module vid_trig_seq_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        arm = 1'b0;
  logic [9:0]  word_i = '0;
  logic        word_vld = 1'b0;
  logic [9:0]  cfg_pre0 = 10'h3FF, cfg_pre1 = 10'h000, cfg_pre2 = 10'h000;
  logic [10:0] cfg_line = '0;
  logic [15:0] cfg_count = '0;
  logic        trig_o;
  logic [2:0]  stage_o;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  string tag = "R1";

  // reference model state
  int m_st, m_pos, m_half, m_cnt;
  logic [9:0] m_ln0;
  logic m_trig;

  vid_trig_seq uut (
    .clk(clk), .rst(rst), .arm(arm), .word_i(word_i), .word_vld(word_vld),
    .cfg_pre0(cfg_pre0), .cfg_pre1(cfg_pre1), .cfg_pre2(cfg_pre2),
    .cfg_line(cfg_line), .cfg_count(cfg_count),
    .trig_o(trig_o), .stage_o(stage_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [9:0] ln_a(input logic [10:0] l);
    return {1'b0, l[6:0], 2'b00};
  endfunction
  function automatic logic [9:0] ln_b(input logic [10:0] l);
    return {4'b0000, l[10:7], 2'b00};
  endfunction
  function automatic logic [9:0] pre_val(input int p);
    return (p == 0) ? cfg_pre0 : (p == 1) ? cfg_pre1 : cfg_pre2;
  endfunction

  task automatic chk(input string t, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", t, act, expv, $time);
    end
  endtask

  task automatic m_reset();
    m_st = 0; m_pos = 0; m_half = 0; m_cnt = 0; m_ln0 = '0; m_trig = 1'b0;
  endtask

  // Model of one clock edge, written from the requirements
  task automatic m_step(input logic a, input logic v, input logic [9:0] w);
    int nst;
    m_trig = 1'b0;
    nst = m_st;
    if (a) begin
      nst = 1;
    end else if (v) begin
      case (m_st)
        1, 3: begin
          if (m_pos == 3) begin
            if (w[6] == (m_st == 1)) nst = (m_st == 1) ? 2 : 4;
            m_pos = (w == cfg_pre0) ? 1 : 0;
          end else if (w == pre_val(m_pos)) m_pos++;
          else m_pos = (w == cfg_pre0) ? 1 : 0;
        end
        2: begin
          if (m_half == 0) begin m_ln0 = w; m_half = 1; end
          else nst = ({w[5:2], m_ln0[8:2]} == cfg_line) ? 3 : 1;
        end
        4: begin
          if (m_cnt == int'(cfg_count)) begin m_trig = 1'b1; nst = 5; end
          else m_cnt++;
        end
        default: ;
      endcase
    end
    if (nst != m_st || a) begin m_pos = 0; m_half = 0; m_cnt = 0; end
    m_st = nst;
  endtask

  task automatic cyc(input logic a, input logic v, input logic [9:0] w);
    @(negedge clk);
    chk({tag, " stage"}, int'(stage_o), m_st);
    chk({tag, " trig"}, int'(trig_o), int'(m_trig));
    arm = a; word_vld = v; word_i = w;
    m_step(a, v, w);
  endtask

  task automatic expect_now(input string t, input int est, input int etrig);
    @(negedge clk);
    chk({t, " stage"}, int'(stage_o), est);
    chk({t, " trig"}, int'(trig_o), etrig);
    chk({t, " model"}, int'(stage_o), m_st);
    arm = 0; word_vld = 0;
    m_step(0, 0, '0);
  endtask

  task automatic set_cfg(input logic [9:0] a0, input logic [9:0] a1, input logic [9:0] a2,
                         input logic [10:0] ln, input logic [15:0] cn);
    @(negedge clk);
    chk({tag, " stage"}, int'(stage_o), m_st);
    cfg_pre0 = a0; cfg_pre1 = a1; cfg_pre2 = a2; cfg_line = ln; cfg_count = cn;
    arm = 0; word_vld = 0;
    m_step(0, 0, '0);
  endtask

  task automatic send(input logic [9:0] w);
    cyc(0, 1, w);
  endtask

  task automatic marker(input bit h);
    send(cfg_pre0); send(cfg_pre1); send(cfg_pre2);
    send(h ? 10'h274 : 10'h200);
  endtask

  task automatic rsend(input logic [9:0] w);
    while ($urandom_range(3) == 0) cyc(0, 0, 10'($urandom));
    if ($urandom_range(60) == 0) cyc(1, 1, w);
    else cyc(0, 1, w);
  endtask

  task automatic rmarker(input bit h);
    rsend(cfg_pre0); rsend(cfg_pre1); rsend(cfg_pre2);
    rsend(10'(($urandom & 32'h3BF) | (h ? 32'h40 : 32'h0)));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    m_reset();
    cfg_line = 11'd21; cfg_count = 16'd2;
    repeat (3) @(negedge clk);
    chk("R1 stage in reset", int'(stage_o), 0);
    chk("R1 trig in reset", int'(trig_o), 0);
    rst = 1'b0;

    tag = "R1"; expect_now("R1 after reset", 0, 0);
    // R2 arm
    tag = "R2"; cyc(1, 0, '0); expect_now("R2 armed", 1, 0);
    // R3 status word with bit 6 clear ignored in stage 1
    tag = "R3"; marker(0); expect_now("R3 wrong marker", 1, 0);
    // R4 broken preamble restarted by a first-preamble word, then full EAV
    tag = "R4";
    send(10'h3FF); send(10'h000); send(10'h3FF); send(10'h000); send(10'h000); send(10'h274);
    expect_now("R4 restart then R3 EAV", 2, 0);
    // R5 matching line
    tag = "R5"; send(ln_a(11'd21)); send(ln_b(11'd21)); expect_now("R5 line match", 3, 0);
    // R6 wrong-flag marker ignored, then SAV
    tag = "R6"; marker(1); expect_now("R6 EAV in stage 3", 3, 0);
    marker(0); expect_now("R6 SAV", 4, 0);
    // R7 count 2 with gap (R9)
    tag = "R7"; send(10'h111); cyc(0, 0, 10'h3FF); send(10'h112);
    expect_now("R7 before last word", 4, 0);
    send(10'h113); expect_now("R7 fire", 5, 1);
    expect_now("R7 pulse width", 5, 0);
    // R8 done holds
    tag = "R8"; marker(1); send(ln_a(11'd21)); send(ln_b(11'd21)); marker(0);
    repeat (4) send(10'h155);
    expect_now("R8 done holds", 5, 0);
    // R5 mismatching line returns to stage 1
    tag = "R5"; cyc(1, 0, '0); marker(1); send(ln_a(11'd22)); send(ln_b(11'd21));
    expect_now("R5 line mismatch", 1, 0);
    // R9 invalid words do nothing
    tag = "R9"; cyc(0, 0, 10'h3FF); cyc(0, 0, 10'h000); cyc(0, 0, 10'h000); cyc(0, 0, 10'h274);
    expect_now("R9 invalid marker ignored", 1, 0);
    // R2 coincidence: arm with the firing word; count zero
    tag = "R2"; set_cfg(10'h3FF, 10'h000, 10'h000, 11'd21, 16'd0);
    marker(1); send(ln_a(11'd21)); send(ln_b(11'd21)); marker(0);
    expect_now("R2 in count stage", 4, 0);
    cyc(1, 1, 10'h0AA); expect_now("R2 arm beats fire", 1, 0);
    // R7 count zero fires on first word
    tag = "R7"; marker(1); send(ln_a(11'd21)); send(ln_b(11'd21)); marker(0);
    send(10'h0AA); expect_now("R7 count zero fire", 5, 1);
    // R10 new comparator values and line
    tag = "R10"; set_cfg(10'h155, 10'h0AA, 10'h2AA, 11'd1100, 16'd1);
    cyc(1, 0, '0);
    send(10'h3FF); send(10'h000); send(10'h000); send(10'h274);
    expect_now("R10 old preamble ignored", 1, 0);
    marker(1); send(ln_a(11'd1100)); send(ln_b(11'd1100)); marker(0);
    send(10'h001); send(10'h002); expect_now("R10 new settings fire", 5, 1);

    // Constrained random rounds checked every cycle against the model
    for (int r = 0; r < 160; r++) begin
      logic [10:0] ln;
      tag = "R10";
      ln = 11'($urandom_range(1125, 1));
      if (r % 4 == 3)
        set_cfg(10'($urandom), 10'($urandom), 10'($urandom), ln, 16'($urandom_range(5)));
      else
        set_cfg(10'h3FF, 10'h000, 10'h000, ln, 16'($urandom_range(5)));
      tag = "R7";
      cyc(1, 0, '0);
      for (int k = 0; k < 14; k++) begin
        case ($urandom_range(5))
          0: rsend(10'($urandom));
          1: begin
            tag = "R3"; rmarker(1); tag = "R5";
            if ($urandom_range(2) == 0) begin rsend(ln_a(ln + 11'd1)); rsend(ln_b(ln)); end
            else begin rsend(ln_a(ln)); rsend(ln_b(ln)); end
          end
          2: begin tag = "R6"; rmarker($urandom_range(3) == 0); end
          3: begin tag = "R4"; rsend(cfg_pre0); rsend(cfg_pre1); rsend(cfg_pre0); end
          4: begin tag = "R7"; repeat ($urandom_range(4)) rsend(10'($urandom)); end
          default: begin tag = "R9"; repeat ($urandom_range(3)) cyc(0, 0, cfg_pre0); end
        endcase
      end
    end

    tag = "R8"; expect_now("R8 final", m_st, 0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule